// File: doc/BRIEF.md
# Oscillator Control Register with Hardware Forcing

This block holds the enable, ready and configuration state for a small clock unit with two oscillators: an on-chip 48 MHz source (the "internal" oscillator) and an off-chip crystal or clock input (the "external" oscillator). Software reads and writes one register word. The power controller, the system clock multiplexer and a clock failure monitor can override what software has written. Hardware wins every conflict, so software cannot stop an oscillator that the chip still depends on.

Each oscillator has a ready flag driven by its own stabilisation counter. The flag rises a parameterised number of cycles after the oscillator starts. It drops six register-clock cycles after the oscillator stops. When a clock failure is seen on the external oscillator while supervision is armed, the block raises a fallback request. That request makes the internal oscillator the effective system source and keeps it running until the clock multiplexer reports an internal-derived source again. The three divider fields are only stored and read back.

The register port is a plain synchronous strobe. A write with `wr_en` high is taken at that clock edge, and there is no back-pressure. `rd_data` shows the current register state combinationally. All hardware pins are plain levels.

Top module: `osc_ctl_reg`

## Requirements
- R1: After reset, `rd_data` reads 0x00000001: the internal enable (bit 0) is set and every other bit is clear. `fallback_req`, `css_det_en` and both ready flags are low.
- R2: Bit 1 (kernel keep-alive) and the three 3-bit divider fields at bits [10:8], [14:12] and [18:16] hold the value last written and read it back one cycle after the write.
- R3: The ready flags read at bit 2 (internal) and bit 5 (external). Written values of those bits are ignored.
- R4: When `pwr_mode` is not 0 (0 run, 1 stop, 2 standby, 3 shutdown), the internal enable bit is forced to 0 at the next edge. This overrides software and R5.
- R5: In run mode, when the effective system source is internal-derived, the internal enable bit is forced to 1 at the next edge. The source is internal-derived when `fallback_req` is high or `sys_src[0]` is 0 (`sys_src`: 0 internal, 1 external, 2 PLL from internal, 3 PLL from external).
- R6: With bit 1 set, `int_osc_en` is high in run and stop modes regardless of bit 0. It is not kept high in standby or shutdown.
- R7: A ready flag rises STAB edges after its oscillator starts (INT_STAB_CYC or EXT_STAB_CYC). If the oscillator stops before then, the count starts over.
- R8: A ready flag that is high falls on the sixth clock edge after its oscillator stops.
- R9: The external enable (bit 4) is forced to 0 whenever `pwr_mode` is not 0. A software clear of it is ignored while the effective source is external-derived (`sys_src[0]` is 1 and no fallback).
- R10: A write to the bypass bit (bit 6, driving `ext_bypass`) takes effect only while bit 4 is 0.
- R11: The supervision enable (bit 7) can be set by software but is cleared only by reset.
- R12: `css_det_en` is high only while bit 7 is set, `ext_rdy` is high and no failure has been caught since the external flag was last low. An `ext_fail` pulse while `css_det_en` is low has no effect.
- R13: `ext_fail` while `css_det_en` is high raises `fallback_req` and drops `css_det_en` at the same edge. The fallback then forces bit 0 high and allows bit 4 to be cleared. It ends at the first edge where `sys_src[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, taken at the edge |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Current register word |
| pwr_mode | input | 2 | 0 run, 1 stop, 2 standby, 3 shutdown |
| sys_src | input | 2 | Current system clock source from the multiplexer |
| ext_fail | input | 1 | External oscillator failure indication |
| int_osc_en | output | 1 | Run request to the internal oscillator |
| ext_osc_en | output | 1 | Run request to the external oscillator |
| ext_bypass | output | 1 | External oscillator bypass select |
| int_rdy | output | 1 | Internal oscillator ready |
| ext_rdy | output | 1 | External oscillator ready |
| css_det_en | output | 1 | Clock failure detector enable |
| fallback_req | output | 1 | Request to switch the system clock to the internal oscillator |

## Verification
A stabilisation counter that is off by one shows up as a ready flag edge one cycle early or late, so rise and fall are checked on the exact edge on both sides. A wrong forcing priority or a lost sticky bit appears in `rd_data` on the cycle right after the write or the mode change. A fallback latch in the wrong state shows on `fallback_req` at the failure edge, and one cycle later in bit 0. Each check samples one register stage after its cause, so a bad internal state is seen within one cycle, except for the counters, which need their full window.

// File: rtl/osc_ctl_pkg.sv
package osc_ctl_pkg;
  localparam logic [1:0] PWR_RUN = 2'd0;

  localparam int B_INT_EN  = 0;
  localparam int B_KEEP_ON = 1;
  localparam int B_INT_RDY = 2;
  localparam int B_EXT_EN  = 4;
  localparam int B_EXT_RDY = 5;
  localparam int B_EXT_BYP = 6;
  localparam int B_CSS_EN  = 7;

  localparam int DIV_W     = 3;
  localparam int DIV_NUM   = 3;
  localparam int REG_MIN_W = 19;

  function automatic int div_lsb(input int idx);
    return 8 + 4 * idx;
  endfunction
endpackage

// File: rtl/osc_ready_tracker.sv
module osc_ready_tracker #(
  parameter int STAB_CYC = 16,
  parameter int FALL_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_on,
  output logic rdy
);
  localparam int MAXC = (STAB_CYC > FALL_CYC) ? STAB_CYC : FALL_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] STAB_LAST = CW'(STAB_CYC - 1);
  localparam logic [CW-1:0] FALL_LAST = CW'(FALL_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          rdy_q;

  // one counter times both the start-up window and the stop delay
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (osc_on) begin
      if (rdy_q) begin
        cnt_q <= '0;
      end else if (cnt_q == STAB_LAST) begin
        rdy_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (!rdy_q) begin
        cnt_q <= '0;
      end else if (cnt_q == FALL_LAST) begin
        rdy_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rdy = rdy_q;

  // R7
  rise_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> $past(osc_on));
  // R8
  fall_needs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_q) |-> $past(!osc_on));
endmodule

// File: rtl/osc_fail_guard.sv
module osc_fail_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic css_en,
  input  logic ext_rdy,
  input  logic ext_fail,
  input  logic src_is_int,
  output logic det_on,
  output logic fb_req
);
  logic tripped_q;
  logic fb_q;
  logic hit;

  assign det_on = css_en & ext_rdy & ~tripped_q;
  assign hit    = det_on & ext_fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tripped_q <= 1'b0;
      fb_q      <= 1'b0;
    end else begin
      if (hit)          tripped_q <= 1'b1;
      else if (!ext_rdy) tripped_q <= 1'b0;
      if (hit)             fb_q <= 1'b1;
      else if (src_is_int) fb_q <= 1'b0;
    end
  end

  assign fb_req = fb_q;

  // R12
  det_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_on && ext_fail) |=> !det_on);
  // R13
  fb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_q) |-> $past(ext_fail));
endmodule

// File: rtl/osc_ctl_reg.sv
module osc_ctl_reg
  import osc_ctl_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int INT_STAB_CYC = 16,
  parameter int EXT_STAB_CYC = 64,
  parameter int FALL_CYC     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        pwr_mode,
  input  logic [1:0]        sys_src,
  input  logic              ext_fail,
  output logic              int_osc_en,
  output logic              ext_osc_en,
  output logic              ext_bypass,
  output logic              int_rdy,
  output logic              ext_rdy,
  output logic              css_det_en,
  output logic              fallback_req
);
  localparam int N_OSC = 2;

  logic int_en_q, keep_q, ext_en_q, byp_q, css_q;
  logic int_en_d, keep_d, ext_en_d, byp_d, css_d;
  logic [DIV_W-1:0] div_q [DIV_NUM];

  logic lp, eff_int, eff_ext;
  logic [N_OSC-1:0] osc_on_v, rdy_v;
  logic unused_wr;

  assign lp      = (pwr_mode != PWR_RUN);
  assign eff_int = fallback_req | ~sys_src[0];
  assign eff_ext = ~fallback_req & sys_src[0];

  always_comb begin
    int_en_d = wr_en ? wr_data[B_INT_EN] : int_en_q;
    if (lp)           int_en_d = 1'b0;
    else if (eff_int) int_en_d = 1'b1;

    ext_en_d = wr_en ? wr_data[B_EXT_EN] : ext_en_q;
    if (eff_ext && ext_en_q) ext_en_d = 1'b1;
    if (lp)                  ext_en_d = 1'b0;

    byp_d  = (wr_en && !ext_en_q) ? wr_data[B_EXT_BYP] : byp_q;
    css_d  = css_q | (wr_en & wr_data[B_CSS_EN]);
    keep_d = wr_en ? wr_data[B_KEEP_ON] : keep_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en_q <= 1'b1;
      keep_q   <= 1'b0;
      ext_en_q <= 1'b0;
      byp_q    <= 1'b0;
      css_q    <= 1'b0;
    end else begin
      int_en_q <= int_en_d;
      keep_q   <= keep_d;
      ext_en_q <= ext_en_d;
      byp_q    <= byp_d;
      css_q    <= css_d;
    end
  end

  genvar gd;
  generate
    for (gd = 0; gd < DIV_NUM; gd++) begin : g_div
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     div_q[gd] <= '0;
        else if (wr_en) div_q[gd] <= wr_data[div_lsb(gd) +: DIV_W];
      end
    end
  endgenerate

  assign int_osc_en = int_en_q | (keep_q & ~pwr_mode[1]);
  assign ext_osc_en = ext_en_q;
  assign ext_bypass = byp_q;
  assign osc_on_v   = {ext_en_q, int_osc_en};

  genvar go;
  generate
    for (go = 0; go < N_OSC; go++) begin : g_osc
      osc_ready_tracker #(
        .STAB_CYC(go == 0 ? INT_STAB_CYC : EXT_STAB_CYC),
        .FALL_CYC(FALL_CYC)
      ) u_trk (
        .clk   (clk),
        .rst_n (rst_n),
        .osc_on(osc_on_v[go]),
        .rdy   (rdy_v[go])
      );
    end
  endgenerate

  assign int_rdy = rdy_v[0];
  assign ext_rdy = rdy_v[1];

  osc_fail_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .css_en    (css_q),
    .ext_rdy   (ext_rdy),
    .ext_fail  (ext_fail),
    .src_is_int(~sys_src[0]),
    .det_on    (css_det_en),
    .fb_req    (fallback_req)
  );

  always_comb begin
    rd_data = '0;
    rd_data[B_INT_EN]  = int_en_q;
    rd_data[B_KEEP_ON] = keep_q;
    rd_data[B_INT_RDY] = int_rdy;
    rd_data[B_EXT_EN]  = ext_en_q;
    rd_data[B_EXT_RDY] = ext_rdy;
    rd_data[B_EXT_BYP] = byp_q;
    rd_data[B_CSS_EN]  = css_q;
    for (int i = 0; i < DIV_NUM; i++) rd_data[div_lsb(i) +: DIV_W] = div_q[i];
  end

  assign unused_wr = ^{wr_data[DATA_W-1:REG_MIN_W], wr_data[15], wr_data[11],
                       wr_data[B_EXT_RDY], wr_data[3], wr_data[B_INT_RDY]};

  // R4
  lp_int_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp |=> !int_en_q);
  // R5
  src_int_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp && eff_int) |=> int_en_q);
  // R9
  lp_ext_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp |=> !ext_en_q);
  // R10
  byp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en_q |=> $stable(byp_q));
  // R11
  css_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    css_q |=> css_q);
endmodule

// File: tb/tb_osc_ctl_reg.sv
module tb_osc_ctl_reg;
  localparam int DW = 32;
  localparam logic [31:0] MASK = 32'h000777D3;
  localparam int NV = 11;
  // {pwr_mode, sys_src, wr_data, expected masked rd_data}
  localparam logic [67:0] VEC [NV] = '{
    {2'd0, 2'd0, 32'h00000000, 32'h00000001},  // R5
    {2'd0, 2'd1, 32'h00000000, 32'h00000000},  // R2
    {2'd0, 2'd1, 32'h00031242, 32'h00031242},  // R2 R10
    {2'd0, 2'd1, 32'h00031252, 32'h00031252},  // R2
    {2'd0, 2'd1, 32'h00031202, 32'h00031252},  // R9 R10
    {2'd0, 2'd0, 32'h00000002, 32'h00000043},  // R10
    {2'd0, 2'd0, 32'h00000084, 32'h00000081},  // R11
    {2'd0, 2'd1, 32'h00000000, 32'h00000080},  // R11
    {2'd1, 2'd1, 32'h00000011, 32'h00000080},  // R4 R9
    {2'd0, 2'd2, 32'h00000000, 32'h00000081},  // R5
    {2'd2, 2'd2, 32'h00000001, 32'h00000080}   // R4
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [1:0] pwr_mode = 2'd0;
  logic [1:0] sys_src = 2'd0;
  logic ext_fail = 1'b0;
  logic int_osc_en, ext_osc_en, ext_bypass, int_rdy, ext_rdy, css_det_en, fallback_req;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  osc_ctl_reg #(.DATA_W(DW), .INT_STAB_CYC(8), .EXT_STAB_CYC(12), .FALL_CYC(6)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pwr_mode(pwr_mode), .sys_src(sys_src), .ext_fail(ext_fail),
    .int_osc_en(int_osc_en), .ext_osc_en(ext_osc_en), .ext_bypass(ext_bypass),
    .int_rdy(int_rdy), .ext_rdy(ext_rdy), .css_det_en(css_det_en), .fallback_req(fallback_req));

  function automatic string vreq(input int i);
    case (i)
      0, 9:    return "R5";
      1, 2, 3: return "R2";
      4:       return "R9";
      5:       return "R10";
      6, 7:    return "R11";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; pwr_mode = 2'd0; sys_src = 2'd0; ext_fail = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 rd_data", rd_data, 32'h00000001);
    chk("R1 flags", {28'd0, fallback_req, css_det_en, int_rdy, ext_rdy}, 32'h0);
    chk("R1 osc pins", {29'd0, int_osc_en, ext_osc_en, ext_bypass}, 32'h4);

    for (int i = 0; i < NV; i++) begin
      pwr_mode = VEC[i][67:66];
      sys_src  = VEC[i][65:64];
      wr(VEC[i][63:32]);
      chk(vreq(i), rd_data & MASK, VEC[i][31:0]);
    end

    // R7: rise timing and restart on early stop
    do_reset();
    wr(32'h10);
    tick(5);
    wr(32'h00);
    wr(32'h10);
    chk("R7 ext_osc_en", {31'd0, ext_osc_en}, 32'h1);
    tick(11);
    chk("R7 restart not ready", {31'd0, ext_rdy}, 32'h0);
    tick(1);
    chk("R7 ready", {31'd0, ext_rdy}, 32'h1);
    // R8: fall six edges after stop
    wr(32'h00);
    tick(5);
    chk("R8 still ready", {31'd0, ext_rdy}, 32'h1);
    tick(1);
    chk("R8 dropped", {31'd0, ext_rdy}, 32'h0);
    // R3: flag bits ignore writes
    wr(32'h24);
    chk("R3 flag bits", rd_data & 32'h24, 32'h04);

    // R6: kernel keep-alive across modes
    do_reset();
    sys_src = 2'd1;
    wr(32'h0);
    chk("R6 off", {31'd0, int_osc_en}, 32'h0);
    tick(10);
    chk("R6 int_rdy low", {31'd0, int_rdy}, 32'h0);
    wr(32'h2);
    chk("R6 run keep", {30'd0, int_osc_en, rd_data[0]}, 32'h2);
    pwr_mode = 2'd1;
    tick(1);
    chk("R6 stop keep", {31'd0, int_osc_en}, 32'h1);
    tick(8);
    chk("R6 R7 int ready", {31'd0, int_rdy}, 32'h1);
    pwr_mode = 2'd2;
    tick(1);
    chk("R6 standby off", {31'd0, int_osc_en}, 32'h0);
    sys_src = 2'd0;
    pwr_mode = 2'd1;
    tick(1);
    chk("R4 over R5", rd_data & 32'h1, 32'h0);

    // R11 R12 R13: supervision and fallback
    do_reset();
    wr(32'h90);
    chk("R12 off before ready", {31'd0, css_det_en}, 32'h0);
    ext_fail = 1'b1;
    tick(1);
    ext_fail = 1'b0;
    chk("R12 fail ignored", {31'd0, fallback_req}, 32'h0);
    tick(12);
    chk("R12 on", {31'd0, css_det_en}, 32'h1);
    sys_src = 2'd3;
    wr(32'h10);
    chk("R11 sticky", rd_data & 32'h91, 32'h90);
    ext_fail = 1'b1;
    tick(1);
    ext_fail = 1'b0;
    chk("R13 fallback", {30'd0, fallback_req, css_det_en}, 32'h2);
    tick(1);
    chk("R13 int forced", {30'd0, rd_data[0], int_osc_en}, 32'h3);
    wr(32'h80);
    chk("R13 ext clear allowed", {31'd0, ext_osc_en}, 32'h0);
    sys_src = 2'd0;
    tick(1);
    chk("R13 fallback ends", {31'd0, fallback_req}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule